// File: doc/BRIEF.md
# Secure Memory Region Access Filter

This block sits in front of a memory controller and decides, for every request from a bus master, whether the request may go on to memory or must be refused with a bus abort. Each request carries an address, a read/write direction and a one-bit security attribute. The attribute is 0 for the secure world and 1 for the non-secure world. The block compares the address against a small set of programmable address windows. Where several enabled windows cover the address, the window with the highest number decides. That window's 4-bit permission field holds separate read and write grants for each world. A window can therefore be shared with the non-secure world for reads while writes stay secure-only.

Window 0 is a fixed background window that spans the whole address space. Only its permission can be changed. The other windows each have an inclusive lower and upper bound, a permission field and an enable. Secure firmware programs them through a single-cycle write port. A write from the non-secure world is dropped and raises a sticky violation flag. The outcome of each request appears exactly one cycle after the request, either as a forwarded request or as an abort strobe. The first refused address is kept in a sticky status register.

Top module: `tz_region_filter`

## Requirements
- R1: After reset, no forward or abort strobe is active, both sticky flags are clear, window 0 holds permission 0xC, and every other window is disabled.
- R2: Each cycle with `req_valid` high produces, one cycle later, exactly one of `fwd_valid` or `abort_stb`. A cycle without a request produces neither.
- R3: A forwarded request presents the address, direction and security attribute of the original request unchanged.
- R4: An enabled window matches an address when the address lies between its lower and upper bound, both bounds included.
- R5: When several enabled windows match, the one with the highest number supplies the permission.
- R6: Permission bits are: bit 3 secure read, bit 2 secure write, bit 1 non-secure write, bit 0 non-secure read. A request passes only when its bit is set. For example, 0xF grants everything, 0xC grants secure access only, and 0xD adds non-secure reads to secure access.
- R7: Window 0 always matches every address. Writes to its bounds or its enable have no effect, but its permission can be written.
- R8: A disabled window takes no part in matching.
- R9: On the first refused request, `abort_flag` goes high and `abort_addr` records the request address, in the same cycle as the abort strobe. Both then hold until reset.
- R10: A configuration write with `cfg_ns` high changes no window and sets the sticky `cfg_viol` flag.
- R11: The configuration port selects a field with `cfg_fld`: 0 is the lower bound, 1 the upper bound, and 2 the attribute word. In the attribute word, bit 0 is the enable and bits 7:4 are the permission. A write takes effect from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ns | input | 1 | 1 = non-secure world |
| fwd_valid | output | 1 | Request forwarded to memory |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_write | output | 1 | Forwarded direction |
| fwd_ns | output | 1 | Forwarded security attribute |
| abort_stb | output | 1 | Request refused (bus abort) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ns | input | 1 | Security attribute of the configuration write |
| cfg_idx | input | IDX_W | Window number |
| cfg_fld | input | 2 | Field select |
| cfg_wdata | input | ADDR_W | Write data |
| abort_flag | output | 1 | Sticky: an abort has occurred |
| abort_addr | output | ADDR_W | Address of the first abort |
| cfg_viol | output | 1 | Sticky: a non-secure configuration write was seen |

## Verification
A corrupted bound, enable or permission register shows up as a wrong forward-or-abort decision. That decision appears one cycle after the first request that touches the affected address and direction. For this reason, every window layout is followed by a sweep of every address with all four direction and world combinations. A lost or mis-timed sticky flag, or a captured address that drifts, shows up on the status outputs. These are compared after every request, so a fault there is visible within one cycle.

// File: rtl/tzrf_pkg.sv
package tzrf_pkg;
   localparam int PERM_W = 4;
   // permission bit positions
   localparam int P_SR = 3;
   localparam int P_SW = 2;
   localparam int P_NW = 1;
   localparam int P_NR = 0;
   // attribute word layout
   localparam int ATTR_EN_BIT   = 0;
   localparam int ATTR_PERM_LSB = 4;

   typedef enum logic [1:0] {
      FLD_BASE = 2'd0,
      FLD_TOP  = 2'd1,
      FLD_ATTR = 2'd2
   } cfg_fld_e;

   function automatic logic perm_grants(input logic [PERM_W-1:0] p,
                                        input logic ns, input logic wr);
      logic g;
      if (ns) g = wr ? p[P_NW] : p[P_NR];
      else    g = wr ? p[P_SW] : p[P_SR];
      return g;
   endfunction
endpackage

// File: rtl/tzrf_region_bank.sv
module tzrf_region_bank
   import tzrf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 9,
   parameter int IDX_W       = 4,
   parameter logic [PERM_W-1:0] RESET_PERM0 = 4'hC
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cfg_we,
   input  logic                                   cfg_ns,
   input  logic [IDX_W-1:0]                       cfg_idx,
   input  logic [1:0]                             cfg_fld,
   input  logic [ADDR_W-1:0]                      cfg_wdata,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     base_o,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     top_o,
   output logic [NUM_REGIONS-1:0][PERM_W-1:0]     perm_o,
   output logic [NUM_REGIONS-1:0]                 en_o,
   output logic                                   viol_o
);
   logic wr_ok;
   logic [PERM_W-1:0] perm_wdata;

   assign wr_ok      = cfg_we && !cfg_ns;
   assign perm_wdata = cfg_wdata[ATTR_PERM_LSB +: PERM_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                viol_o <= 1'b0;
      else if (cfg_we && cfg_ns) viol_o <= 1'b1;
   end

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
      logic sel;
      assign sel = wr_ok && (cfg_idx == IDX_W'(g));

      if (g == 0) begin : g_default
         logic [PERM_W-1:0] perm_q;
         assign base_o[g] = '0;
         assign top_o[g]  = '1;
         assign en_o[g]   = 1'b1;
         assign perm_o[g] = perm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) perm_q <= RESET_PERM0;
            else if (sel && cfg_fld == FLD_ATTR) perm_q <= perm_wdata;
         end
      end else begin : g_prog
         logic [ADDR_W-1:0] base_q, top_q;
         logic [PERM_W-1:0] perm_q;
         logic              en_q;
         assign base_o[g] = base_q;
         assign top_o[g]  = top_q;
         assign en_o[g]   = en_q;
         assign perm_o[g] = perm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q <= '0;
               top_q  <= '0;
               perm_q <= '0;
               en_q   <= 1'b0;
            end else if (sel) begin
               unique case (cfg_fld)
                  FLD_BASE: base_q <= cfg_wdata;
                  FLD_TOP:  top_q  <= cfg_wdata;
                  FLD_ATTR: begin
                     en_q   <= cfg_wdata[ATTR_EN_BIT];
                     perm_q <= perm_wdata;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/tzrf_match.sv
module tzrf_match
   import tzrf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 9,
   parameter int IDX_W       = 4
) (
   input  logic [ADDR_W-1:0]                   addr,
   input  logic                                wr,
   input  logic                                ns,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_i,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  top_i,
   input  logic [NUM_REGIONS-1:0][PERM_W-1:0]  perm_i,
   input  logic [NUM_REGIONS-1:0]              en_i,
   output logic [IDX_W-1:0]                    win_idx,
   output logic                                allow
);
   logic [NUM_REGIONS-1:0] hit;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
      assign hit[g] = en_i[g] && (addr >= base_i[g]) && (addr <= top_i[g]);
   end

   // highest-numbered matching window wins
   always_comb begin
      win_idx = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hit[i]) win_idx = IDX_W'(i);
      end
   end

   assign allow = perm_grants(perm_i[win_idx], ns, wr);
endmodule

// File: rtl/tz_region_filter.sv
module tz_region_filter
   import tzrf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 9,
   parameter logic [3:0] RESET_PERM0 = 4'hC,
   localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_ns,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              fwd_write,
   output logic              fwd_ns,
   output logic              abort_stb,
   input  logic              cfg_we,
   input  logic              cfg_ns,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [1:0]        cfg_fld,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              abort_flag,
   output logic [ADDR_W-1:0] abort_addr,
   output logic              cfg_viol
);
   if (NUM_REGIONS < 2 || NUM_REGIONS > 16) begin : g_bad_regions
      $error("tz_region_filter: NUM_REGIONS must be 2..16");
   end
   if (ADDR_W < ATTR_PERM_LSB + PERM_W) begin : g_bad_width
      $error("tz_region_filter: ADDR_W too small for attribute word");
   end

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_w, top_w;
   logic [NUM_REGIONS-1:0][PERM_W-1:0] perm_w;
   logic [NUM_REGIONS-1:0]             en_w;
   logic [IDX_W-1:0]                   win_idx;
   logic                               allow;

   tzrf_region_bank #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W),
      .RESET_PERM0(RESET_PERM0)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ns(cfg_ns), .cfg_idx(cfg_idx),
      .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
      .base_o(base_w), .top_o(top_w), .perm_o(perm_w), .en_o(en_w),
      .viol_o(cfg_viol)
   );

   tzrf_match #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)
   ) u_match (
      .addr(req_addr), .wr(req_write), .ns(req_ns),
      .base_i(base_w), .top_i(top_w), .perm_i(perm_w), .en_i(en_w),
      .win_idx(win_idx), .allow(allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid  <= 1'b0;
         fwd_addr   <= '0;
         fwd_write  <= 1'b0;
         fwd_ns     <= 1'b0;
         abort_stb  <= 1'b0;
         abort_flag <= 1'b0;
         abort_addr <= '0;
      end else begin
         fwd_valid <= req_valid && allow;
         abort_stb <= req_valid && !allow;
         if (req_valid && allow) begin
            fwd_addr  <= req_addr;
            fwd_write <= req_write;
            fwd_ns    <= req_ns;
         end
         if (req_valid && !allow && !abort_flag) begin
            abort_flag <= 1'b1;
            abort_addr <= req_addr;
         end
      end
   end
endmodule

// File: rtl/tzrf_checker.sv
module tzrf_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              req_ns,
   input logic              fwd_valid,
   input logic [ADDR_W-1:0] fwd_addr,
   input logic              fwd_write,
   input logic              fwd_ns,
   input logic              abort_stb,
   input logic              cfg_we,
   input logic              cfg_ns,
   input logic              abort_flag,
   input logic [ADDR_W-1:0] abort_addr,
   input logic              cfg_viol
);
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_valid && abort_stb)); // R2
   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (fwd_valid || abort_stb)); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(fwd_valid || abort_stb)); // R2
   AST_FWD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!fwd_valid || (fwd_addr == $past(req_addr) &&
                     fwd_write == $past(req_write) && fwd_ns == $past(req_ns)))); // R3
   AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      abort_stb |-> abort_flag); // R9
   AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      abort_flag |=> (abort_flag && $stable(abort_addr))); // R9
   AST_NS_CFG_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_ns) |=> cfg_viol); // R10
   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_viol |=> cfg_viol); // R10
endmodule

bind tz_region_filter tzrf_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_write(req_write), .req_ns(req_ns), .fwd_valid(fwd_valid),
   .fwd_addr(fwd_addr), .fwd_write(fwd_write), .fwd_ns(fwd_ns),
   .abort_stb(abort_stb), .cfg_we(cfg_we), .cfg_ns(cfg_ns),
   .abort_flag(abort_flag), .abort_addr(abort_addr), .cfg_viol(cfg_viol)
);

// File: tb/tz_region_filter_tb_top.sv
module tz_region_filter_tb_top;
   localparam int AW = 8;
   localparam int NR = 4;
   localparam int IW = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          fwd_valid, fwd_write, fwd_ns, abort_stb, abort_flag, cfg_viol;
   logic [AW-1:0] fwd_addr, abort_addr;
   logic          cfg_we = 1'b0, cfg_ns = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [1:0]    cfg_fld = '0;
   logic [AW-1:0] cfg_wdata = '0;

   tz_region_filter #(.ADDR_W(AW), .NUM_REGIONS(NR), .RESET_PERM0(4'hC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_ns(req_ns), .fwd_valid(fwd_valid),
      .fwd_addr(fwd_addr), .fwd_write(fwd_write), .fwd_ns(fwd_ns),
      .abort_stb(abort_stb), .cfg_we(cfg_we), .cfg_ns(cfg_ns),
      .cfg_idx(cfg_idx), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
      .abort_flag(abort_flag), .abort_addr(abort_addr), .cfg_viol(cfg_viol)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench model of the window set
   logic [AW-1:0] m_base [NR];
   logic [AW-1:0] m_top  [NR];
   logic [3:0]    m_perm [NR];
   logic          m_en   [NR];
   logic          exp_flag = 1'b0;
   logic [AW-1:0] exp_addr = '0;
   logic          exp_viol = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // R4 R5 R6 R8: inclusive bounds, highest enabled window, bit mapping
   function automatic logic model_allow(input logic [AW-1:0] a, input logic w, input logic ns);
      int win = 0;
      int bitpos;
      for (int i = 0; i < NR; i++)
         if (m_en[i] && a >= m_base[i] && a <= m_top[i]) win = i;
      bitpos = ns ? (w ? 1 : 0) : (w ? 2 : 3);
      return m_perm[win][bitpos];
   endfunction

   // R11: field 0 lower bound, 1 upper bound, 2 attribute {perm[7:4], en[0]}
   task automatic cfg(input int idx, input logic [1:0] fld, input logic [AW-1:0] d, input logic ns);
      cfg_we = 1'b1; cfg_ns = ns; cfg_idx = IW'(idx); cfg_fld = fld; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_ns = 1'b0;
      if (ns) exp_viol = 1'b1;               // R10
      else if (idx == 0) begin               // R7
         if (fld == 2'd2) m_perm[0] = d[7:4];
      end else begin
         case (fld)
            2'd0: m_base[idx] = d;
            2'd1: m_top[idx]  = d;
            2'd2: begin m_en[idx] = d[0]; m_perm[idx] = d[7:4]; end
            default: ;
         endcase
      end
      chk("R10 cfg_viol", 32'(cfg_viol), 32'(exp_viol));
   endtask

   task automatic set_win(input int idx, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                          input logic [3:0] p, input logic en);
      cfg(idx, 2'd0, lo, 1'b0);
      cfg(idx, 2'd1, hi, 1'b0);
      cfg(idx, 2'd2, {p, 3'b000, en}, 1'b0);
   endtask

   task automatic do_req(input logic [AW-1:0] a, input logic w, input logic ns);
      logic ok;
      req_valid = 1'b1; req_addr = a; req_write = w; req_ns = ns;
      @(negedge clk);
      req_valid = 1'b0;
      ok = model_allow(a, w, ns);
      chk("R2 R4 R5 R6 R8 fwd_valid", 32'(fwd_valid), 32'(ok));
      chk("R2 abort_stb", 32'(abort_stb), 32'(!ok));
      if (ok) begin
         chk("R3 fwd_addr", 32'(fwd_addr), 32'(a));
         chk("R3 fwd_write/ns", 32'({fwd_write, fwd_ns}), 32'({w, ns}));
      end else if (!exp_flag) begin
         exp_flag = 1'b1;
         exp_addr = a;
      end
      chk("R9 abort_flag", 32'(abort_flag), 32'(exp_flag));
      if (exp_flag) chk("R9 abort_addr", 32'(abort_addr), 32'(exp_addr));
   endtask

   task automatic sweep();
      for (int a = 0; a < (1 << AW); a++)
         for (int c = 0; c < 4; c++)
            do_req(AW'(a), c[0], c[1]);
      @(negedge clk);
      chk("R2 idle fwd", 32'(fwd_valid), 32'd0);
      chk("R2 idle abort", 32'(abort_stb), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < NR; i++) begin
         m_base[i] = '0; m_top[i] = '0; m_perm[i] = '0; m_en[i] = 1'b0;
      end
      m_top[0] = '1; m_en[0] = 1'b1; m_perm[0] = 4'hC;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 fwd_valid", 32'(fwd_valid), 32'd0);
      chk("R1 abort_stb", 32'(abort_stb), 32'd0);
      chk("R1 abort_flag", 32'(abort_flag), 32'd0);
      chk("R1 cfg_viol", 32'(cfg_viol), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R7: default window secure-only everywhere
      sweep();
      // layered windows, overlapping (R5), single-address window (R4)
      cfg(0, 2'd2, 8'hF0, 1'b0);
      set_win(1, 8'h40, 8'h7F, 4'hD, 1'b1);
      set_win(2, 8'h70, 8'h9F, 4'hC, 1'b1);
      set_win(3, 8'h60, 8'h60, 4'h5, 1'b1);
      sweep();
      // R8: disable window 2
      cfg(2, 2'd2, {4'hC, 4'h0}, 1'b0);
      sweep();
      // R7: window 0 bounds and enable are fixed
      cfg(0, 2'd0, 8'h10, 1'b0);
      cfg(0, 2'd1, 8'h20, 1'b0);
      cfg(0, 2'd2, 8'hE0, 1'b0);
      sweep();
      // R10: non-secure configuration write ignored
      cfg(1, 2'd2, 8'hF1, 1'b1);
      cfg(3, 2'd1, 8'hFF, 1'b1);
      sweep();
      chk("R10 cfg_viol sticky", 32'(cfg_viol), 32'd1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule